// File: doc/BRIEF.md
# Standby Wake-on-Debug-Access Controller

This controller sits between a debug bus slave port of the APB kind and the standby control of a processor core. While the core runs, debug transfers pass straight through to the debug register block. When the core has gone into low-power standby, a debug transfer makes the controller raise a wake request. The transfer is held with wait states until the core has reported itself awake for a set number of cycles. The transfer is then forwarded and completed, and the controller sends the core back into standby. No reset is issued at any point, so processor and debug state survive the round trip.

A halting debug request seen during standby also wakes the core, and in that case the core stays awake. If standby was entered through a wait-for-interrupt or wait-for-event instruction, the controller reports that instruction as retired. A normal wake event that arrives during a bus-triggered wake also cancels the return to standby. Only the select, enable and ready strobes pass through the controller. Address and data go beside it to the debug register block.

Top module: `dbg_standby_waker`

## Requirements
- R1: After reset the controller is in the awake state: wake_req, sleep_req and insn_retired are all low.
- R2: While awake, m_psel and m_penable follow s_psel and s_penable, and s_pready equals m_pready, so no wait state is added.
- R3: A stby_enter pulse while awake puts the controller into standby. In standby, m_psel and m_penable stay low and s_pready stays low.
- R4: A transfer (s_psel high) seen in standby raises wake_req from the next cycle. s_pready stays low until core_awake has been high on AWAKE_SEEN consecutive cycles.
- R5: In the cycle after the last of those AWAKE_SEEN cycles, the transfer is forwarded and s_pready equals m_pready.
- R6: After a bus-triggered wake, the first cycle with s_psel low is followed by a cycle in which sleep_req pulses high for exactly one cycle with wake_req low. The controller is then back in standby.
- R7: While s_psel stays high across back-to-back transfers, wake_req stays high and sleep_req stays low.
- R8: A halt_req seen in standby wakes the core (wake_req high from the next cycle). Once core_awake qualifies, the controller is awake with no sleep_req, and transfers complete without wait states.
- R9: insn_retired pulses for one cycle when halt_req is seen outside the awake state and standby was entered with stby_by_wfx high. It does not pulse if stby_by_wfx was low, and it pulses at most once per standby episode.
- R10: A halt_req or wake_evt during a bus-triggered wake, including in the cycle that would issue sleep_req, suppresses the return to standby and leaves the controller awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_psel | input | 1 | Debug bus select from the master |
| s_penable | input | 1 | Debug bus enable (access phase) from the master |
| s_pready | output | 1 | Ready returned to the master; low inserts wait states |
| m_psel | output | 1 | Forwarded select to the debug register block |
| m_penable | output | 1 | Forwarded enable to the debug register block |
| m_pready | input | 1 | Ready from the debug register block |
| core_awake | input | 1 | Core reports it is out of standby |
| stby_enter | input | 1 | Pulse: core has entered standby |
| stby_by_wfx | input | 1 | Qualifies stby_enter: entry came from a wait-for-interrupt or wait-for-event instruction |
| halt_req | input | 1 | Halting debug request |
| wake_evt | input | 1 | Normal wake event (interrupt or event) |
| wake_req | output | 1 | Request for the core to leave standby |
| sleep_req | output | 1 | One-cycle pulse sending the core back into standby |
| insn_retired | output | 1 | One-cycle pulse: the standby-entry instruction is retired |

## Verification
The critical coincidence is a halting request or wake event in the same cycle that the bus episode ends. That cycle is either the idle cycle after the last transfer or the cycle that would issue sleep_req. A directed case puts wake_evt exactly in the return cycle. The random phase sprinkles halt_req and wake_evt over bus episodes whose length depends on random downstream wait states. A cycle model in the bench judges every cycle: sleep_req must be withheld, the controller must land awake, and a halting request must pulse insn_retired only when the entry was by instruction.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [2:0] {
    ST_ASLEEP    = 3'd0,
    ST_WAKING    = 3'd1,
    ST_SERVING   = 3'd2,
    ST_RETURNING = 3'd3,
    ST_AWAKE     = 3'd4
  } sw_state_t;

  // bus may reach the debug registers in this state
  function automatic logic path_open(input sw_state_t st);
    return (st == ST_AWAKE) || (st == ST_SERVING);
  endfunction

  // controller holds the core out of standby
  function automatic logic holds_wake(input sw_state_t st);
    return (st == ST_WAKING) || (st == ST_SERVING);
  endfunction

  // something other than the bus wants the core kept running
  function automatic logic keep_running(input logic halt, input logic evt);
    return halt | evt;
  endfunction

  // return-to-standby strobe, withheld when a keep-running cause shows up
  function automatic logic sleep_fire(input sw_state_t st, input logic halt, input logic evt);
    return (st == ST_RETURNING) && !keep_running(halt, evt);
  endfunction

  // the standby-entry instruction retires on a halting exit
  function automatic logic retire_fire(input sw_state_t st, input logic halt, input logic pend);
    return halt && pend && (st != ST_AWAKE);
  endfunction

endpackage

// File: rtl/sw_fsm.sv
module sw_fsm
  import sw_pkg::*;
#(
  parameter int AWAKE_SEEN = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_sel,
  input  logic      halt_req,
  input  logic      wake_evt,
  input  logic      core_awake,
  input  logic      stby_enter,
  output sw_state_t cur_st
);
  localparam int CW = (AWAKE_SEEN < 2) ? 1 : $clog2(AWAKE_SEEN);
  localparam logic [CW-1:0] SEEN_LAST = CW'(AWAKE_SEEN - 1);

  sw_state_t st_q, st_d;
  logic      stay_q, stay_d;
  logic [CW-1:0] seen_q, seen_d;
  logic      hold_cause;

  assign hold_cause = keep_running(halt_req, wake_evt);

  always_comb begin
    st_d   = st_q;
    stay_d = stay_q;
    seen_d = seen_q;
    unique case (st_q)
      ST_AWAKE: begin
        stay_d = 1'b0;
        if (stby_enter) st_d = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        seen_d = '0;
        if (hold_cause) begin
          st_d   = ST_WAKING;
          stay_d = 1'b1;
        end else if (bus_sel) begin
          st_d   = ST_WAKING;
          stay_d = 1'b0;
        end
      end
      ST_WAKING: begin
        if (hold_cause) stay_d = 1'b1;
        if (!core_awake) begin
          seen_d = '0;
        end else if (seen_q == SEEN_LAST) begin
          seen_d = '0;
          st_d   = (stay_q || hold_cause) ? ST_AWAKE : ST_SERVING;
        end else begin
          seen_d = seen_q + 1'b1;
        end
      end
      ST_SERVING: begin
        if (hold_cause) stay_d = 1'b1;
        if (!bus_sel) st_d = (stay_q || hold_cause) ? ST_AWAKE : ST_RETURNING;
      end
      ST_RETURNING: begin
        st_d = hold_cause ? ST_AWAKE : ST_ASLEEP;
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_AWAKE;
      stay_q <= 1'b0;
      seen_q <= '0;
    end else begin
      st_q   <= st_d;
      stay_q <= stay_d;
      seen_q <= seen_d;
    end
  end

  assign cur_st = st_q;
endmodule

// File: rtl/sw_retire.sv
module sw_retire
  import sw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sw_state_t cur_st,
  input  logic      stby_enter,
  input  logic      stby_by_wfx,
  input  logic      halt_req,
  output logic      insn_retired
);
  logic pend_q;

  assign insn_retired = retire_fire(cur_st, halt_req, pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (cur_st == ST_AWAKE) begin
      pend_q <= stby_enter & stby_by_wfx;
    end else if (insn_retired) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_bus_gate.sv
module sw_bus_gate
  import sw_pkg::*;
(
  input  sw_state_t cur_st,
  input  logic      s_psel,
  input  logic      s_penable,
  input  logic      m_pready,
  output logic      m_psel,
  output logic      m_penable,
  output logic      s_pready,
  output logic      open_path
);
  assign open_path = path_open(cur_st);
  assign m_psel    = s_psel    & open_path;
  assign m_penable = s_penable & open_path;
  assign s_pready  = m_pready  & open_path;
endmodule

// File: rtl/dbg_standby_waker.sv
module dbg_standby_waker
  import sw_pkg::*;
#(
  parameter int AWAKE_SEEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_psel,
  input  logic s_penable,
  output logic s_pready,
  output logic m_psel,
  output logic m_penable,
  input  logic m_pready,
  input  logic core_awake,
  input  logic stby_enter,
  input  logic stby_by_wfx,
  input  logic halt_req,
  input  logic wake_evt,
  output logic wake_req,
  output logic sleep_req,
  output logic insn_retired
);
  sw_state_t cur_st;
  logic      open_path;

  sw_fsm #(.AWAKE_SEEN(AWAKE_SEEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (s_psel),
    .halt_req   (halt_req),
    .wake_evt   (wake_evt),
    .core_awake (core_awake),
    .stby_enter (stby_enter),
    .cur_st     (cur_st)
  );

  sw_retire u_retire (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_st       (cur_st),
    .stby_enter   (stby_enter),
    .stby_by_wfx  (stby_by_wfx),
    .halt_req     (halt_req),
    .insn_retired (insn_retired)
  );

  sw_bus_gate u_gate (
    .cur_st    (cur_st),
    .s_psel    (s_psel),
    .s_penable (s_penable),
    .m_pready  (m_pready),
    .m_psel    (m_psel),
    .m_penable (m_penable),
    .s_pready  (s_pready),
    .open_path (open_path)
  );

  assign wake_req  = holds_wake(cur_st);
  assign sleep_req = sleep_fire(cur_st, halt_req, wake_evt);
endmodule

// File: rtl/sw_chk.sv
module sw_chk
  import sw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      s_psel,
  input logic      s_pready,
  input logic      m_psel,
  input logic      halt_req,
  input logic      wake_req,
  input logic      sleep_req,
  input logic      insn_retired,
  input logic      open_path,
  input sw_state_t cur_st
);
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !open_path |-> (!s_pready && !m_psel));

  assert_access_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_ASLEEP && s_psel) |=> wake_req);

  assert_sleep_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !sleep_req);

  assert_sleep_drops_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !wake_req);

  assert_burst_no_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_SERVING && s_psel) |=> !sleep_req);

  assert_halt_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_ASLEEP && halt_req) |=> wake_req);

  assert_retire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insn_retired |=> !insn_retired);
endmodule

bind dbg_standby_waker sw_chk u_sw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_psel       (s_psel),
  .s_pready     (s_pready),
  .m_psel       (m_psel),
  .halt_req     (halt_req),
  .wake_req     (wake_req),
  .sleep_req    (sleep_req),
  .insn_retired (insn_retired),
  .open_path    (open_path),
  .cur_st       (cur_st)
);

// File: tb/test_dbg_standby_waker.sv
`timescale 1ns/1ps
module test_dbg_standby_waker;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_psel = 0, s_penable = 0, m_pready = 0, core_awake = 0;
  logic stby_enter = 0, stby_by_wfx = 0, halt_req = 0, wake_evt = 0;
  logic s_pready, m_psel, m_penable, wake_req, sleep_req, insn_retired;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_standby_waker #(.AWAKE_SEEN(N)) i_dbg_standby_waker (
    .clk(clk), .rst_n(rst_n), .s_psel(s_psel), .s_penable(s_penable),
    .s_pready(s_pready), .m_psel(m_psel), .m_penable(m_penable),
    .m_pready(m_pready), .core_awake(core_awake), .stby_enter(stby_enter),
    .stby_by_wfx(stby_by_wfx), .halt_req(halt_req), .wake_evt(wake_evt),
    .wake_req(wake_req), .sleep_req(sleep_req), .insn_retired(insn_retired)
  );

  // bench-side cycle model: 0 run, 1 dozing, 2 rousing, 3 answering, 4 settling
  int md_st = 0;
  bit md_keep = 0, md_pend = 0;
  int md_cnt = 0;

  function automatic bit e_open();   return md_st == 0 || md_st == 3; endfunction
  function automatic bit e_wake();   return md_st == 2 || md_st == 3; endfunction
  function automatic bit e_sleep();  return md_st == 4 && !halt_req && !wake_evt; endfunction
  function automatic bit e_retire(); return halt_req && md_pend && md_st != 0; endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    check(wake_req == e_wake(), "R4 wake_req", wake_req, e_wake());
    check(sleep_req == e_sleep(), "R6 sleep_req", sleep_req, e_sleep());
    check(insn_retired == e_retire(), "R9 insn_retired", insn_retired, e_retire());
    check(s_pready == (m_pready & e_open()), md_st == 0 ? "R2 s_pready" : "R5 s_pready",
          s_pready, m_pready & e_open());
    check(m_psel == (s_psel & e_open()), "R3 m_psel", m_psel, s_psel & e_open());
  endtask

  task automatic model_step();
    bit hc;
    hc = halt_req | wake_evt;
    if (e_retire()) md_pend = 0;
    case (md_st)
      0: begin
        md_keep = 0;
        md_pend = stby_enter & stby_by_wfx;
        if (stby_enter) md_st = 1;
      end
      1: begin
        md_cnt = 0;
        if (hc) begin md_st = 2; md_keep = 1; end
        else if (s_psel) begin md_st = 2; md_keep = 0; end
      end
      2: begin
        if (hc) md_keep = 1;
        if (!core_awake) md_cnt = 0;
        else if (md_cnt == N - 1) begin md_cnt = 0; md_st = md_keep ? 0 : 3; end
        else md_cnt++;
      end
      3: begin
        if (hc) md_keep = 1;
        if (!s_psel) md_st = md_keep ? 0 : 4;
      end
      default: md_st = hc ? 0 : 1;
    endcase
  endtask

  // called just after a falling edge with inputs already set
  task automatic cycle();
    #1;
    model_compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int mst;
    process::self().srandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1;
    check(!wake_req && !sleep_req && !insn_retired, "R1 idle outputs",
          {wake_req, sleep_req, insn_retired}, 0);
    cycle();

    // R2 awake transfer without waits
    m_pready = 1; s_psel = 1; cycle();
    s_penable = 1; #1;
    check(s_pready && m_penable, "R2 pass-through", {s_pready, m_penable}, 3);
    cycle();
    s_psel = 0; s_penable = 0;

    // R3/R4/R5/R6/R7 bus-triggered episode
    stby_enter = 1; stby_by_wfx = 1; cycle();
    stby_enter = 0; s_psel = 1; #1;
    check(!m_psel && !s_pready, "R3 blocked in standby", {m_psel, s_pready}, 0);
    cycle();
    s_penable = 1; core_awake = 0; #1;
    check(wake_req && !s_pready, "R4 wake raised, stalled", {wake_req, s_pready}, 2);
    cycle();
    core_awake = 1; cycle();
    #1; check(!s_pready, "R4 still stalled", s_pready, 0);
    cycle();
    #1; check(s_pready, "R5 forwarded", s_pready, 1);
    cycle();
    s_penable = 0; #1;
    check(!sleep_req && wake_req, "R7 burst holds wake", {sleep_req, wake_req}, 1);
    cycle();
    s_penable = 1; cycle();
    s_psel = 0; s_penable = 0; #1;
    check(!sleep_req, "R7 no early sleep", sleep_req, 0);
    cycle();
    #1; check(sleep_req && !wake_req, "R6 return strobe", {sleep_req, wake_req}, 2);
    cycle();
    core_awake = 0;

    // R8/R9 halting exit after wfx entry
    halt_req = 1; #1;
    check(insn_retired, "R9 retire on halt", insn_retired, 1);
    cycle();
    halt_req = 0; core_awake = 1; cycle(); cycle();
    #1; check(!wake_req && !sleep_req, "R8 awake, no sleep", {wake_req, sleep_req}, 0);
    s_psel = 1; cycle();
    s_penable = 1; #1;
    check(s_pready, "R8 no waits after halt", s_pready, 1);
    cycle();
    s_psel = 0; s_penable = 0;

    // R9 no retire without wfx entry
    stby_enter = 1; stby_by_wfx = 0; cycle();
    stby_enter = 0; halt_req = 1; core_awake = 0; #1;
    check(!insn_retired, "R9 no retire w/o wfx", insn_retired, 0);
    cycle();
    halt_req = 0; core_awake = 1; cycle(); cycle();

    // R10 wake event in the return cycle
    stby_enter = 1; stby_by_wfx = 1; cycle();
    stby_enter = 0; s_psel = 1; cycle();
    s_penable = 1; cycle(); cycle();
    #1; check(s_pready, "R10 served", s_pready, 1);
    cycle();
    s_psel = 0; s_penable = 0; cycle();
    wake_evt = 1; #1;
    check(!sleep_req, "R10 sleep withheld", sleep_req, 0);
    cycle();
    wake_evt = 0; #1;
    check(!wake_req, "R10 landed awake", wake_req, 0);
    s_psel = 1; cycle();
    s_penable = 1; #1;
    check(s_pready, "R10 no waits", s_pready, 1);
    cycle();
    s_psel = 0; s_penable = 0;

    // constrained random phase
    mst = 0;
    for (int i = 0; i < 4000; i++) begin
      s_psel      = (mst != 0);
      s_penable   = (mst == 2);
      m_pready    = ($urandom % 4) != 0;
      core_awake  = ($urandom % 3) == 0;
      stby_enter  = (mst == 0) && (($urandom % 8) == 0);
      stby_by_wfx = $urandom % 2;
      halt_req    = ($urandom % 40) == 0;
      wake_evt    = ($urandom % 40) == 0;
      #1;
      if (mst == 2 && s_pready) mst = ($urandom % 2) ? 1 : 0;
      else if (mst == 1) mst = 2;
      else if (mst == 0) mst = (!stby_enter && ($urandom % 3) == 0) ? 1 : 0;
      #0;
      // cycle() waits #1 more; inputs unchanged so checks are consistent
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule